// File: doc/BRIEF.md
# Power-On Reset Override Controller

This block owns the internal reset of a timekeeping core. After power becomes good it keeps the core in reset for a long power-on interval. That interval stands in for the start-up time of a slow crystal oscillator. Board test cannot wait that long, so the block also provides an early way out. While reset is still held, it watches the two-wire bus data and clock lines. When it sees a fixed sequence of edges, and each phase of that sequence is long enough, it releases the reset at once. At the same moment it sends a one-cycle pulse that restarts the downstream seconds prescaler from its preload.

A test-control bit, written through a write strobe with a data bit, gates this escape. The bit comes up set after power-on, so the override is allowed out of reset. Writing 0 to the bit ends an active override and blocks any new entry until 1 is written again. Once the power-on interval has run out, writing 0 to the bit has no visible effect.

All minimum intervals are set in nanoseconds and converted to system clock cycles, rounding up, using a clock-frequency parameter given in MHz. Both bus lines pass through two-flop synchronizers before they are used.

Top module: `por_override_ctrl`

## Requirements
- R1: While `pwr_good` is low, `core_reset` is 1, `ovr_active` is 0 and `presc_release` is 0. The test-control bit returns to 1.
- R2: If no override occurs, `core_reset` falls once POR_CYC = ceil(POR_NS*CLK_MHZ/1000) cycles have passed after the synchronized release of `pwr_good`.
- R3: Bus-line activity is ignored until SETTLE_CYC = ceil(SETTLE_NS*CLK_MHZ/1000) cycles have passed after power-up. A complete sequence given earlier does not enter override.
- R4: The entry sequence, in this order, is: both lines high; `sda_in` falls while `scl_in` is high; `scl_in` falls; `scl_in` rises; `sda_in` rises while `scl_in` is high. Any other edge during the sequence restarts detection, and detection then waits for both lines to be high again.
- R5: `scl_in` must stay low for at least SHORT_CYC = ceil(SHORT_NS*CLK_MHZ/1000) cycles. A shorter low phase is rejected.
- R6: `scl_in` must be high for at least LONG_CYC = ceil(LONG_NS*CLK_MHZ/1000) cycles before `sda_in` rises. A shorter gap is rejected.
- R7: After a valid sequence, `ovr_active` becomes 1 and `core_reset` becomes 0 after the third rising clock edge that follows the final `sda_in` rise. Neither changes after the second edge.
- R8: `presc_release` is a pulse exactly one cycle wide. It is issued once per override entry, in the same cycle that `ovr_active` rises.
- R9: A write with `tc_wdata`=0 clears `ovr_active` on the next edge. If the power-on interval has not expired, `core_reset` returns to 1.
- R10: While the test-control bit is 0, a valid sequence does not enter override. After 1 is written, a valid sequence enters override again.
- R11: After the power-on interval has expired, a write with `tc_wdata`=0 leaves `core_reset` at 0.
- R12: If a write with `tc_wdata`=0 falls in the same cycle as sequence completion, the write wins: no override is entered and no `presc_release` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Raw power-good; low resets the block asynchronously |
| sda_in | input | 1 | Data line level, asynchronous |
| scl_in | input | 1 | Clock line level, asynchronous |
| tc_wr | input | 1 | Write strobe for the test-control bit |
| tc_wdata | input | 1 | Value written to the test-control bit |
| core_reset | output | 1 | Internal reset of the core, active high |
| ovr_active | output | 1 | High while the override holds the core out of reset |
| presc_release | output | 1 | One-cycle pulse that restarts the prescaler |

## Verification
Two events can land in the same cycle: completion of the entry sequence and a software write that clears the test-control bit. The bench makes them collide by raising `sda_in` and then asserting a write of 0 exactly two falling edges later. That places the write in the cycle where the synchronized rising edge is evaluated. It then checks that `ovr_active` stays low, `core_reset` stays high and no prescaler pulse is counted. It also checks `ovr_active` in the cycles just before and just after the entry edge, so that a one-cycle error in timing is caught.

// File: rtl/por_ovr_pkg.sv
package por_ovr_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,  // wait for both lines high
    SQ_ARMED  = 3'd1,  // both high, waiting for data to fall
    SQ_DAT_LO = 3'd2,  // data low, clock high
    SQ_CLK_LO = 3'd3,  // clock low phase, timed
    SQ_CLK_HI = 3'd4   // clock high again, timed until data rises
  } seq_state_t;

  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned mhz);
    return int'((ns * mhz + 64'd999) / 64'd1000);
  endfunction
endpackage

// File: rtl/por_ovr_sync.sv
module por_ovr_sync #(
  parameter int unsigned W       = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/por_ovr_timer.sv
module por_ovr_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);

  // once expired the interval stays expired until power is lost
  p_timer_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/por_ovr_seq.sv
module por_ovr_seq
  import por_ovr_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 16,
  parameter int unsigned LONG_CYC  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sda,
  input  logic scl,
  output logic hit
);
  localparam int unsigned MAXC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_CYC);
  localparam logic [CW-1:0] SAT_L   = CW'(MAXC);

  seq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (cnt_q == SAT_L) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (!en) begin
      st_d  = SQ_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (sda && scl) st_d = SQ_ARMED;
        SQ_ARMED: begin
          if (!scl)      st_d = SQ_IDLE;
          else if (!sda) st_d = SQ_DAT_LO;
        end
        SQ_DAT_LO: begin
          if (sda) st_d = SQ_IDLE;
          else if (!scl) begin
            st_d  = SQ_CLK_LO;
            cnt_d = CW'(1);
          end
        end
        SQ_CLK_LO: begin
          if (sda) st_d = SQ_IDLE;
          else if (scl) begin
            if (cnt_q >= SHORT_L) begin
              st_d  = SQ_CLK_HI;
              cnt_d = CW'(1);
            end else begin
              st_d = SQ_IDLE;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
        SQ_CLK_HI: begin
          if (!scl) st_d = SQ_IDLE;
          else if (sda) begin
            hit  = (cnt_q >= LONG_L);
            st_d = SQ_IDLE;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // the timed high phase is only reached after an accepted low phase
  p_hi_after_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_CLK_HI && $past(st_q) != SQ_CLK_HI) |-> $past(st_q) == SQ_CLK_LO);
  // completion is only possible from the timed high phase with the clock high
  p_hit_from_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (st_q == SQ_CLK_HI && scl && en));
  // detection is held idle whenever it is not enabled
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st_q == SQ_IDLE);
endmodule

// File: rtl/por_override_ctrl.sv
module por_override_ctrl
  import por_ovr_pkg::*;
#(
  parameter longint unsigned CLK_MHZ   = 32,
  parameter longint unsigned SETTLE_NS = 8_000_000,
  parameter longint unsigned SHORT_NS  = 500,
  parameter longint unsigned LONG_NS   = 2000,
  parameter longint unsigned POR_NS    = 600_000_000
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic sda_in,
  input  logic scl_in,
  input  logic tc_wr,
  input  logic tc_wdata,
  output logic core_reset,
  output logic ovr_active,
  output logic presc_release
);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
  localparam int unsigned SHORT_CYC  = ns_to_cyc(SHORT_NS, CLK_MHZ);
  localparam int unsigned LONG_CYC   = ns_to_cyc(LONG_NS, CLK_MHZ);
  localparam int unsigned POR_CYC    = ns_to_cyc(POR_NS, CLK_MHZ);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [1:0] lines_s;
  logic sda_s, scl_s;
  por_ovr_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(lines_s));
  assign sda_s = lines_s[1];
  assign scl_s = lines_s[0];

  logic settle_done, por_done;
  por_ovr_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .done(settle_done));
  por_ovr_timer #(.LIMIT(POR_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .done(por_done));

  logic testc_q, testc_d, ovr_q, ovr_d, pulse_q, pulse_d;
  logic seq_en, seq_hit, clr_wr, accept;

  assign seq_en = settle_done & ~por_done & ~ovr_q & testc_q;

  por_ovr_seq #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(seq_en), .sda(sda_s), .scl(scl_s), .hit(seq_hit));

  always_comb begin
    clr_wr  = tc_wr & ~tc_wdata;
    accept  = seq_hit & ~clr_wr;          // a clearing write wins a tie
    testc_d = tc_wr ? tc_wdata : testc_q;
    ovr_d   = ovr_q;
    if (clr_wr)      ovr_d = 1'b0;
    else if (accept) ovr_d = 1'b1;
    pulse_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      testc_q <= 1'b1;
      ovr_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      testc_q <= testc_d;
      ovr_q   <= ovr_d;
      pulse_q <= pulse_d;
    end
  end

  assign core_reset    = ~(por_done | ovr_q);
  assign ovr_active    = ovr_q;
  assign presc_release = pulse_q;

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    presc_release |=> !presc_release);
  p_pulse_with_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_active) |-> presc_release);
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_wr && !tc_wdata) |=> (!ovr_active && !presc_release));
  p_entry_needs_testc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_active) |-> $past(testc_q));
  p_override_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_active |-> !core_reset);
  p_expired_stays_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_reset && !ovr_active) |=> !core_reset);
endmodule

// File: tb/por_override_ctrl_bench.sv
module por_override_ctrl_bench;
  localparam int POR_C    = 4000;  // 500000 ns at 8 MHz
  localparam int SHORT_C  = 4;     // 500 ns at 8 MHz
  localparam int LONG_C   = 16;    // 2000 ns at 8 MHz
  localparam int NV       = 6;
  // columns: low phase, high gap, data glitch in low phase, override expected
  localparam int TBL [NV][4] = '{
    '{SHORT_C,     LONG_C,     0, 1},
    '{SHORT_C - 1, LONG_C,     0, 0},
    '{SHORT_C,     LONG_C - 1, 0, 0},
    '{10,          40,         0, 1},
    '{SHORT_C + 2, LONG_C,     1, 0},
    '{SHORT_C,     LONG_C + 1, 0, 1}
  };

  logic clk = 1'b0;
  logic pwr_good, sda_in, scl_in, tc_wr, tc_wdata;
  logic core_reset, ovr_active, presc_release;
  int errors = 0, checks = 0, pulses = 0;
  bit done_flag = 0;
  logic ovr_n2, ovr_n3;

  always #4 clk = ~clk;

  por_override_ctrl #(
    .CLK_MHZ(8), .SETTLE_NS(10_000), .SHORT_NS(500), .LONG_NS(2000), .POR_NS(500_000)
  ) u_por_override_ctrl (
    .clk(clk), .pwr_good(pwr_good), .sda_in(sda_in), .scl_in(scl_in),
    .tc_wr(tc_wr), .tc_wdata(tc_wdata), .core_reset(core_reset),
    .ovr_active(ovr_active), .presc_release(presc_release));

  always @(posedge clk) if (presc_release === 1'b1) pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic power_cycle();
    @(negedge clk);
    pwr_good = 1'b0; sda_in = 1'b1; scl_in = 1'b1; tc_wr = 1'b0; tc_wdata = 1'b0;
    repeat (3) @(negedge clk);
    pwr_good = 1'b1;
  endtask

  task automatic write_tc(input logic v);
    @(negedge clk); tc_wr = 1'b1; tc_wdata = v;
    @(negedge clk); tc_wr = 1'b0;
  endtask

  // drives the entry sequence; clash puts a clearing write on the completion cycle
  task automatic run_seq(input int lo, input int hi, input bit glitch, input bit clash);
    @(negedge clk); sda_in = 1'b0;
    repeat (3) @(negedge clk);
    scl_in = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      if (glitch && i == 1) sda_in = 1'b1;
      if (glitch && i == 2) sda_in = 1'b0;
    end
    scl_in = 1'b1;
    repeat (hi) @(negedge clk);
    sda_in = 1'b1;                 // n0
    @(negedge clk);                // n1
    @(negedge clk);                // n2
    ovr_n2 = ovr_active;
    if (clash) begin tc_wr = 1'b1; tc_wdata = 1'b0; end
    @(negedge clk);                // n3
    tc_wr = 1'b0;
    ovr_n3 = ovr_active;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int p0;
    pwr_good = 1'b0; sda_in = 1'b1; scl_in = 1'b1; tc_wr = 1'b0; tc_wdata = 1'b0;
    repeat (4) @(negedge clk);
    // R1: held in reset
    check(core_reset === 1'b1, "R1 core_reset", core_reset, 1);
    check(ovr_active === 1'b0, "R1 ovr_active", ovr_active, 0);
    check(presc_release === 1'b0, "R1 presc_release", presc_release, 0);

    // table of sequences (R4 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      power_cycle();
      repeat (100) @(negedge clk);
      p0 = pulses;
      run_seq(TBL[v][0], TBL[v][1], TBL[v][2] != 0, 1'b0);
      check(ovr_n2 === 1'b0, $sformatf("R7 early edge vec %0d", v), ovr_n2, 0);
      check(ovr_n3 === 1'(TBL[v][3]), $sformatf("R4 R5 R6 R7 entry vec %0d", v), ovr_n3, TBL[v][3]);
      check(core_reset === 1'(TBL[v][3] == 0), $sformatf("R7 reset vec %0d", v),
            core_reset, TBL[v][3] == 0);
      check(pulses - p0 == TBL[v][3], $sformatf("R8 pulses vec %0d", v), pulses - p0, TBL[v][3]);
    end

    // R1: test-control bit back to 1 after power cycle: entry works without a write
    power_cycle();
    repeat (100) @(negedge clk);
    run_seq(SHORT_C, LONG_C, 1'b0, 1'b0);
    check(ovr_active === 1'b1, "R1 testc reset value", ovr_active, 1);

    // R9 clear, then R10 blocked, then re-entry
    write_tc(1'b0);
    @(negedge clk);
    check(ovr_active === 1'b0, "R9 cleared", ovr_active, 0);
    check(core_reset === 1'b1, "R9 reset back", core_reset, 1);
    p0 = pulses;
    run_seq(SHORT_C, LONG_C, 1'b0, 1'b0);
    check(ovr_active === 1'b0, "R10 blocked", ovr_active, 0);
    check(pulses == p0, "R10 no pulse", pulses - p0, 0);
    write_tc(1'b1);
    run_seq(SHORT_C, LONG_C, 1'b0, 1'b0);
    check(ovr_active === 1'b1, "R10 reentry", ovr_active, 1);

    // R3: sequence before settle interval ignored
    power_cycle();
    run_seq(SHORT_C, LONG_C, 1'b0, 1'b0);
    check(ovr_active === 1'b0, "R3 too early", ovr_active, 0);

    // R12: clearing write coincides with completion
    power_cycle();
    repeat (100) @(negedge clk);
    p0 = pulses;
    run_seq(SHORT_C, LONG_C, 1'b0, 1'b1);
    check(ovr_n3 === 1'b0, "R12 no entry", ovr_n3, 0);
    check(pulses == p0, "R12 no pulse", pulses - p0, 0);
    check(core_reset === 1'b1, "R12 still reset", core_reset, 1);

    // R2: natural release, then R11
    power_cycle();
    repeat (POR_C - 5) @(negedge clk);
    check(core_reset === 1'b1, "R2 before expiry", core_reset, 1);
    repeat (10) @(negedge clk);
    check(core_reset === 1'b0, "R2 after expiry", core_reset, 0);
    write_tc(1'b0);
    repeat (3) @(negedge clk);
    check(core_reset === 1'b0, "R11 write zero no effect", core_reset, 0);
    check(ovr_active === 1'b0, "R11 no override", ovr_active, 0);

    finish_run();
  end
endmodule